// File: doc/BRIEF.md
# Active Priority Tracker with Non-Maskable Flags

This block holds the active priority state of one interrupt controller CPU interface for three interrupt groups: group 0, secure group 1 and non-secure group 1. Each group owns a small array of priority words; bits 31:0 of a word mark active priority slots and bit 63 marks that the activation in that word was taken as a non-maskable interrupt. The tracker records activations, undoes the most urgent activation of a group on a priority drop, and accepts whole-word writes from the register path.

From the three groups it derives a 64-bit running priority. The low bits give the most urgent active slot scaled by the minimum binary point, or the idle value 0xFF. Two upper bits report whether that most urgent word carries a non-maskable flag. Which groups feed those bits depends on the security-disable setting, the current security state and whether the highest exception level is present.

Top module: `nmi_active_prio_tracker`

## Requirements
- R1: After reset every word of every group is clear and `rpr` reads 0x00000000000000FF.
- R2: An activation of group code g (0 = group 0, 1 = secure group 1, 2 = non-secure group 1) with slot s sets bit s mod 32 of word s / 32 of group g; when NMI_EN is set and `act_nmi` is high it also sets bit 63 of that same word.
- R3: `rpr` bits 61:0 equal (32*i + b) << (MIN_BPR + 1), where i is the lowest word index whose bits 31:0, ORed over the three groups, are non-zero and b is the lowest set bit of that OR.
- R4: When no group has any bit 31:0 set in any word, `rpr` is exactly 0xFF with bits 63:62 clear.
- R5: With `sec_disable` high, `rpr` bit 63 is set when bit 63 of word i (from R3) is set in any of the three groups.
- R6: With `sec_disable` low, `rpr` bit 63 follows bit 63 of word i of the non-secure group 1 when `cur_nonsecure` is high, and of the secure group 1 when it is low.
- R7: `rpr` bit 62 is set exactly when `has_el3` is high and bit 63 of word i of the non-secure group 1 is set.
- R8: A drop for group g clears the lowest set bit of bits 31:0 in the lowest-indexed word of g with non-zero bits 31:0, and clears bit 63 of that word; a group with no such word is left unchanged.
- R9: A write stores `wr_data` bits 31:0 and, when NMI_EN is set, bit 63 into word `wr_word` of group `wr_grp`; bits 62:32 are stored as zero.
- R10: When several operations hit in one cycle, the drop is applied first, then the activation, then the write.
- R11: Group code 3 on any operation changes nothing.
- R12: Each operation is reflected on `rpr` from the clock edge that samples it, and `rpr` follows `sec_disable`, `cur_nonsecure` and `has_el3` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | Record an activation this cycle |
| act_grp | input | 2 | Group code of the activation |
| act_slot | input | SLOT_W | Priority slot being activated |
| act_nmi | input | 1 | Activation is non-maskable |
| drop_valid | input | 1 | Perform a priority drop this cycle |
| drop_grp | input | 2 | Group code of the drop |
| wr_valid | input | 1 | Write one priority word this cycle |
| wr_grp | input | 2 | Group code of the write |
| wr_word | input | WIDX_W | Word index of the write |
| wr_data | input | 64 | Word value to store |
| sec_disable | input | 1 | Single security state configuration |
| cur_nonsecure | input | 1 | Current security state is non-secure |
| has_el3 | input | 1 | Highest exception level is implemented |
| rpr | output | 64 | Running priority with non-maskable indicator bits |

## Verification
State is held in one register stage, so an activation, drop or write presented before an edge is due on `rpr` right after that edge, while a change of the security inputs is due in the same cycle without any edge. The bench drives all inputs on the falling edge, advances its own model of the three groups at the rising edge with the values that edge samples, and compares `rpr` at the next falling edge, one cycle per comparison. Directed sequences cover each requirement, including collisions of drop, activation and write in one cycle, and a long random run exercises everything together.

// File: rtl/apt_pkg.sv
// Shared constants, group codes and helpers for the active priority tracker.
// Assumes a 64-bit priority word: slots in bits 31:0, non-maskable flag in bit 63.
package apt_pkg;

    localparam int WORD_W     = 64;
    localparam int SLOTS_PER  = 32;
    localparam int FLAG_BIT   = 63;
    localparam int NSFLAG_BIT = 62;
    localparam int NUM_GRP    = 3;
    localparam logic [63:0] IDLE_RPR = 64'h0000_0000_0000_00FF;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_S1   = 2'd1,
        GRP_NS1  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    // Index of the lowest set bit of a 32-bit value (0 when the value is zero).
    function automatic logic [4:0] lowest_bit(input logic [31:0] v);
        logic [4:0] r;
        r = 5'd0;
        for (int k = SLOTS_PER - 1; k >= 0; k--) begin
            if (v[k]) r = 5'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/apt_group_bank.sv
// One group's active priority words.
// Applies, in this order, a drop, an activation and a write that address this group.
// Assumes the group code GRP_ID is 0..2; code 3 never matches a bank.
module apt_group_bank #(
    parameter int         WORDS  = 2,
    parameter int         SLOT_W = 6,
    parameter int         WIDX_W = 1,
    parameter bit         NMI_EN = 1'b1,
    parameter logic [1:0] GRP_ID = 2'd0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     act_valid,
    input  logic [1:0]               act_grp,
    input  logic [SLOT_W-1:0]        act_slot,
    input  logic                     act_nmi,
    input  logic                     drop_valid,
    input  logic [1:0]               drop_grp,
    input  logic                     wr_valid,
    input  logic [1:0]               wr_grp,
    input  logic [WIDX_W-1:0]        wr_word,
    input  logic [63:0]              wr_data,
    output logic [WORDS-1:0][31:0]   slot_q,
    output logic [WORDS-1:0]         flag_q
);

    logic [WORDS-1:0][31:0] slot_d;
    logic [WORDS-1:0]       flag_d;
    logic                   drop_hit;
    logic                   act_hit;
    logic                   wr_hit;
    logic                   dropped;
    int                     act_word;

    assign drop_hit = drop_valid && (drop_grp == GRP_ID);
    assign act_hit  = act_valid  && (act_grp  == GRP_ID);
    assign wr_hit   = wr_valid   && (wr_grp   == GRP_ID);
    assign act_word = int'(act_slot) / apt_pkg::SLOTS_PER;

    // Next-state: drop, then activate, then write.
    always_comb begin
        slot_d  = slot_q;
        flag_d  = flag_q;
        dropped = 1'b0;
        if (drop_hit) begin
            for (int i = 0; i < WORDS; i++) begin
                if (!dropped && (slot_d[i] != 32'd0)) begin
                    slot_d[i] = slot_d[i] & (slot_d[i] - 32'd1);
                    flag_d[i] = 1'b0;
                    dropped   = 1'b1;
                end
            end
        end
        if (act_hit) begin
            for (int i = 0; i < WORDS; i++) begin
                if (i == act_word) begin
                    slot_d[i][act_slot[4:0]] = 1'b1;
                    if (NMI_EN && act_nmi) flag_d[i] = 1'b1;
                end
            end
        end
        if (wr_hit) begin
            for (int i = 0; i < WORDS; i++) begin
                if (i == int'(wr_word)) begin
                    slot_d[i] = wr_data[31:0];
                    flag_d[i] = NMI_EN ? wr_data[apt_pkg::FLAG_BIT] : 1'b0;
                end
            end
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            flag_q <= '0;
        end else begin
            slot_q <= slot_d;
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/apt_word_scan.sv
// Finds the most urgent active slot across all groups.
// Picks the lowest word index whose slot bits, ORed over groups, are non-zero,
// and the lowest set bit in it; also returns each group's flag for that word.
module apt_word_scan #(
    parameter int WORDS  = 2,
    parameter int WIDX_W = 1
) (
    input  logic [2:0][WORDS-1:0][31:0] slots,
    input  logic [2:0][WORDS-1:0]       flags,
    output logic                        found,
    output logic [WIDX_W-1:0]           idx,
    output logic [4:0]                  pos,
    output logic [2:0]                  sel_flags
);

    logic [WORDS-1:0][31:0] merged;

    // OR the three groups word by word.
    for (genvar w = 0; w < WORDS; w++) begin : g_merge
        assign merged[w] = slots[0][w] | slots[1][w] | slots[2][w];
    end

    // Select the lowest non-zero merged word.
    always_comb begin
        found     = 1'b0;
        idx       = '0;
        pos       = 5'd0;
        sel_flags = 3'b000;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (merged[i] != 32'd0) begin
                found     = 1'b1;
                idx       = WIDX_W'(i);
                pos       = apt_pkg::lowest_bit(merged[i]);
                sel_flags = {flags[2][i], flags[1][i], flags[0][i]};
            end
        end
    end

endmodule

// File: rtl/apt_rpr_compose.sv
// Builds the 64-bit running priority from the scan result.
// Assumes MIN_BPR is small enough that the scaled slot stays below bit 62.
module apt_rpr_compose #(
    parameter int WIDX_W  = 1,
    parameter int MIN_BPR = 2,
    parameter bit NMI_EN  = 1'b1
) (
    input  logic              found,
    input  logic [WIDX_W-1:0] idx,
    input  logic [4:0]        pos,
    input  logic [2:0]        sel_flags,
    input  logic              sec_disable,
    input  logic              cur_nonsecure,
    input  logic              has_el3,
    output logic [63:0]       rpr
);

    localparam int SHIFT = MIN_BPR + 1;

    logic [63:0] slot_num;
    logic [63:0] base;
    logic        nmi_ind;
    logic        nsnmi_ind;

    assign slot_num = 64'(idx) * 64'(apt_pkg::SLOTS_PER) + 64'(pos);
    assign base     = found ? (slot_num << SHIFT) : apt_pkg::IDLE_RPR;

    // Indicator bits exist only when non-maskable support is built in.
    if (NMI_EN) begin : g_nmi
        // Choose the flag sources by security configuration.
        always_comb begin
            if (sec_disable)        nmi_ind = |sel_flags;
            else if (cur_nonsecure) nmi_ind = sel_flags[apt_pkg::GRP_NS1];
            else                    nmi_ind = sel_flags[apt_pkg::GRP_S1];
            nsnmi_ind = has_el3 && sel_flags[apt_pkg::GRP_NS1];
        end
    end else begin : g_no_nmi
        assign nmi_ind   = 1'b0;
        assign nsnmi_ind = 1'b0;
    end

    // Merge indicators into the top bits; they are clear when idle.
    always_comb begin
        rpr = base;
        rpr[apt_pkg::FLAG_BIT]   = found && nmi_ind;
        rpr[apt_pkg::NSFLAG_BIT] = found && nsnmi_ind;
    end

endmodule

// File: rtl/nmi_active_prio_tracker.sv
// Active priority tracker for group 0, secure group 1 and non-secure group 1,
// each word carrying a non-maskable flag, with a running priority output.
// Assumes WORDS is 1..4 and that inputs are synchronous to clk.
module nmi_active_prio_tracker #(
    parameter  int WORDS   = 2,
    parameter  int MIN_BPR = 2,
    parameter  bit NMI_EN  = 1'b1,
    localparam int SLOT_W  = $clog2(WORDS * 32),
    localparam int WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_valid,
    input  logic [1:0]        act_grp,
    input  logic [SLOT_W-1:0] act_slot,
    input  logic              act_nmi,
    input  logic              drop_valid,
    input  logic [1:0]        drop_grp,
    input  logic              wr_valid,
    input  logic [1:0]        wr_grp,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [63:0]       wr_data,
    input  logic              sec_disable,
    input  logic              cur_nonsecure,
    input  logic              has_el3,
    output logic [63:0]       rpr
);

    logic [2:0][WORDS-1:0][31:0] grp_slots;
    logic [2:0][WORDS-1:0]       grp_flags;
    logic                        scan_found;
    logic [WIDX_W-1:0]           scan_idx;
    logic [4:0]                  scan_pos;
    logic [2:0]                  scan_flags;

    // One bank per group.
    for (genvar g = 0; g < apt_pkg::NUM_GRP; g++) begin : g_bank
        apt_group_bank #(
            .WORDS  (WORDS),
            .SLOT_W (SLOT_W),
            .WIDX_W (WIDX_W),
            .NMI_EN (NMI_EN),
            .GRP_ID (2'(g))
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_valid  (act_valid),
            .act_grp    (act_grp),
            .act_slot   (act_slot),
            .act_nmi    (act_nmi),
            .drop_valid (drop_valid),
            .drop_grp   (drop_grp),
            .wr_valid   (wr_valid),
            .wr_grp     (wr_grp),
            .wr_word    (wr_word),
            .wr_data    (wr_data),
            .slot_q     (grp_slots[g]),
            .flag_q     (grp_flags[g])
        );
    end

    apt_word_scan #(
        .WORDS  (WORDS),
        .WIDX_W (WIDX_W)
    ) u_scan (
        .slots     (grp_slots),
        .flags     (grp_flags),
        .found     (scan_found),
        .idx       (scan_idx),
        .pos       (scan_pos),
        .sel_flags (scan_flags)
    );

    apt_rpr_compose #(
        .WIDX_W  (WIDX_W),
        .MIN_BPR (MIN_BPR),
        .NMI_EN  (NMI_EN)
    ) u_compose (
        .found         (scan_found),
        .idx           (scan_idx),
        .pos           (scan_pos),
        .sel_flags     (scan_flags),
        .sec_disable   (sec_disable),
        .cur_nonsecure (cur_nonsecure),
        .has_el3       (has_el3),
        .rpr           (rpr)
    );

endmodule

// File: rtl/apt_checker.sv
// Temporal checks on the tracker's ports, attached by bind.
module apt_checker #(
    parameter int WORDS   = 2,
    parameter int MIN_BPR = 2,
    parameter int SLOT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              act_valid,
    input logic [1:0]        act_grp,
    input logic [SLOT_W-1:0] act_slot,
    input logic              drop_valid,
    input logic              wr_valid,
    input logic              has_el3,
    input logic [63:0]       rpr
);

    localparam int SH = MIN_BPR + 1;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> rpr == 64'hFF);

    // R4
    idle_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpr[61:0] == 62'hFF) |-> (rpr[63:62] == 2'b00));

    // R2
    act_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_grp != 2'd3 && !drop_valid && !wr_valid) |=>
        (rpr[61:0] != 62'hFF) && (rpr[61:0] <= (62'($past(act_slot)) << SH)));

    // R8
    drop_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_valid && !act_valid && !wr_valid) |=>
        (rpr[61:0] == 62'hFF) || (rpr[61:0] >= $past(rpr[61:0])));

    // R7
    nsflag_needs_el3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpr[62] |-> has_el3);

endmodule

bind nmi_active_prio_tracker apt_checker #(
    .WORDS   (WORDS),
    .MIN_BPR (MIN_BPR),
    .SLOT_W  (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_valid  (act_valid),
    .act_grp    (act_grp),
    .act_slot   (act_slot),
    .drop_valid (drop_valid),
    .wr_valid   (wr_valid),
    .has_el3    (has_el3),
    .rpr        (rpr)
);

// File: tb/nmi_active_prio_tracker_tb.sv
`timescale 1ns/1ps
module nmi_active_prio_tracker_tb;

    localparam int WORDS   = 2;
    localparam int MIN_BPR = 2;
    localparam int SLOT_W  = $clog2(WORDS * 32);
    localparam int WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int SH      = MIN_BPR + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              act_valid, act_nmi, drop_valid, wr_valid;
    logic [1:0]        act_grp, drop_grp, wr_grp;
    logic [SLOT_W-1:0] act_slot;
    logic [WIDX_W-1:0] wr_word;
    logic [63:0]       wr_data;
    logic              sec_disable, cur_nonsecure, has_el3;
    logic [63:0]       rpr;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Model state: slot bits and flag per group and word.
    logic [31:0] m_slot [3][WORDS];
    logic        m_flag [3][WORDS];

    always #5 clk = ~clk;

    nmi_active_prio_tracker #(.WORDS(WORDS), .MIN_BPR(MIN_BPR), .NMI_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_grp(act_grp),
        .act_slot(act_slot), .act_nmi(act_nmi), .drop_valid(drop_valid),
        .drop_grp(drop_grp), .wr_valid(wr_valid), .wr_grp(wr_grp),
        .wr_word(wr_word), .wr_data(wr_data), .sec_disable(sec_disable),
        .cur_nonsecure(cur_nonsecure), .has_el3(has_el3), .rpr(rpr));

    function automatic logic [63:0] model_rpr();
        logic [63:0] r;
        r = 64'hFF;
        for (int i = WORDS - 1; i >= 0; i--) begin
            logic [31:0] m;
            m = m_slot[0][i] | m_slot[1][i] | m_slot[2][i];
            if (m != 0) begin
                int b;
                b = 0;
                while (!m[b]) b++;
                r = 64'(i * 32 + b) << SH;
                if (sec_disable) r[63] = m_flag[0][i] | m_flag[1][i] | m_flag[2][i];
                else if (cur_nonsecure) r[63] = m_flag[2][i];
                else r[63] = m_flag[1][i];
                r[62] = has_el3 & m_flag[2][i];
            end
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int g = 0; g < 3; g++)
            for (int i = 0; i < WORDS; i++) begin
                m_slot[g][i] = 0;
                m_flag[g][i] = 0;
            end
    endtask

    // Apply sampled operations: drop, activate, write (R10); code 3 ignored (R11).
    task automatic model_apply();
        if (drop_valid && drop_grp != 2'd3) begin
            for (int i = 0; i < WORDS; i++) begin
                if (m_slot[drop_grp][i] != 0) begin
                    int b;
                    b = 0;
                    while (!m_slot[drop_grp][i][b]) b++;
                    m_slot[drop_grp][i][b] = 1'b0;
                    m_flag[drop_grp][i] = 1'b0;
                    break;
                end
            end
        end
        if (act_valid && act_grp != 2'd3) begin
            m_slot[act_grp][int'(act_slot) / 32][int'(act_slot) % 32] = 1'b1;
            if (act_nmi) m_flag[act_grp][int'(act_slot) / 32] = 1'b1;
        end
        if (wr_valid && wr_grp != 2'd3 && int'(wr_word) < WORDS) begin
            m_slot[wr_grp][wr_word] = wr_data[31:0];
            m_flag[wr_grp][wr_word] = wr_data[63];
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rpr actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        act_valid = 0; act_grp = 0; act_slot = 0; act_nmi = 0;
        drop_valid = 0; drop_grp = 0;
        wr_valid = 0; wr_grp = 0; wr_word = 0; wr_data = 0;
    endtask

    // One clock: model follows the edge, compare at the next falling edge (R12).
    task automatic step();
        @(posedge clk);
        if (rst_n) model_apply(); else model_reset();
        @(negedge clk);
        check(cur_req, rpr, model_rpr());
        idle_inputs();
    endtask

    task automatic do_act(input int g, input int s, input bit n);
        act_valid = 1; act_grp = 2'(g); act_slot = SLOT_W'(s); act_nmi = n;
        step();
    endtask

    task automatic do_drop(input int g);
        drop_valid = 1; drop_grp = 2'(g);
        step();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        sec_disable = 0; cur_nonsecure = 1; has_el3 = 1;
        model_reset();
        @(negedge clk);
        step(); step();
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", rpr, 64'hFF);

        // R2 R3: word 1 slot, then lower slot in another group
        cur_req = "R2";
        do_act(0, 40, 0);
        check("R2", rpr, 64'd40 << SH);
        cur_req = "R3";
        do_act(2, 5, 0);
        check("R3", rpr, 64'd5 << SH);

        // R8 drops, R4 idle
        cur_req = "R8";
        do_drop(2);
        check("R8", rpr, 64'd40 << SH);
        cur_req = "R4";
        do_drop(0);
        check("R4", rpr, 64'hFF);
        cur_req = "R8";
        do_drop(1);
        check("R8", rpr, 64'hFF);

        // R5: security disabled, group 0 flag reported
        cur_req = "R5";
        sec_disable = 1;
        do_act(0, 3, 1);
        check("R5", rpr, 64'h8000_0000_0000_0018);

        // R6 R12: security enabled, only the matching group counts
        cur_req = "R6";
        sec_disable = 0; cur_nonsecure = 1;
        #1 check("R6", rpr, 64'h18);
        do_act(1, 3, 1);
        check("R6", rpr, 64'h18);
        cur_nonsecure = 0;
        #1 check("R12", rpr, 64'h8000_0000_0000_0018);
        @(negedge clk);

        // R7: non-secure group 1 flag with and without EL3
        cur_req = "R7";
        cur_nonsecure = 1;
        do_act(2, 9, 1);
        check("R7", rpr, 64'hC000_0000_0000_0018);
        has_el3 = 0;
        #1 check("R7", rpr, 64'h8000_0000_0000_0018);
        @(negedge clk);
        has_el3 = 1;
        // R8: drop clears the flag of the dropped word
        cur_req = "R8";
        do_drop(2);
        check("R8", rpr, 64'h18);

        // R9: write keeps bits 31:0 and 63 only
        cur_req = "R9";
        do_drop(0); do_drop(1);
        wr_valid = 1; wr_grp = 2'd2; wr_word = 0; wr_data = 64'hFFFF_FFFF_0000_0010;
        step();
        check("R9", rpr, 64'hC000_0000_0000_0000 | (64'd4 << SH));

        // R10: drop and activate same group and cycle
        cur_req = "R10";
        drop_valid = 1; drop_grp = 2'd2;
        act_valid = 1; act_grp = 2'd2; act_slot = SLOT_W'(2); act_nmi = 0;
        step();
        check("R10", rpr, 64'd2 << SH);
        // R10: write overrides activation to the same word
        act_valid = 1; act_grp = 2'd1; act_slot = SLOT_W'(0); act_nmi = 1;
        wr_valid = 1; wr_grp = 2'd1; wr_word = 0; wr_data = 64'h0;
        step();
        check("R10", rpr, 64'd2 << SH);

        // R11: group code 3 ignored
        cur_req = "R11";
        act_valid = 1; act_grp = 2'd3; act_slot = SLOT_W'(0); act_nmi = 1;
        drop_valid = 1; drop_grp = 2'd3;
        wr_valid = 1; wr_grp = 2'd3; wr_word = 0; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        step();
        check("R11", rpr, 64'd2 << SH);

        // Random mixed traffic, compared every cycle
        cur_req = "R12";
        for (int n = 0; n < 3000; n++) begin
            act_valid = ($urandom_range(0, 2) == 0);
            act_grp = 2'($urandom_range(0, 3));
            act_slot = SLOT_W'($urandom_range(0, WORDS * 32 - 1));
            act_nmi = 1'($urandom_range(0, 1));
            drop_valid = ($urandom_range(0, 2) == 0);
            drop_grp = 2'($urandom_range(0, 3));
            wr_valid = ($urandom_range(0, 9) == 0);
            wr_grp = 2'($urandom_range(0, 3));
            wr_word = WIDX_W'($urandom_range(0, WORDS - 1));
            wr_data = {$urandom(), $urandom()} & 64'h8000_0000_0101_0101;
            sec_disable = 1'($urandom_range(0, 1));
            cur_nonsecure = 1'($urandom_range(0, 1));
            has_el3 = 1'($urandom_range(0, 1));
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule